// File: doc/BRIEF.md
# Variable-Latency Instruction Cycle Sequencer

This block sets the execution pace of a small accumulator processor whose instructions take different numbers of clock cycles. When a start pulse arrives while the block is idle, it decodes the opcode of the 16-bit instruction word and records the instruction class. It then loads a 3-bit down-counter from that class's cycle budget. The counter is decoded for its terminal value, and one clock after that value is reached the block raises an end-of-instruction strobe for exactly one cycle.

The strobe and the writeback enables derived from it serve as synchronous clock enables for the accumulator and the overflow flag register. A slow result path, such as a 16-bit multiplier, therefore only has to settle within its instruction's budget and not within a single clock period. The arithmetic units, the memory and the accumulator itself sit outside this block. The block supplies only the timing, the enables and an accumulator source select.

Cycle numbering used below: cycle 1 is the clock period in which `start_i` is high and accepted, so the edge ending cycle 1 is the accepting edge. For an N-cycle instruction, `end_o` is high during cycle N.

Top module: `instr_cycle_seq`

## Requirements
- R1: The opcode is taken from bits [15:10] of `instr_i` only. Bits [9:0] have no effect on the budget or on the writeback enables.
- R2: A jump, opcode 6'b001000, raises `end_o` in cycle 3.
- R3: A memory load, opcode 6'b000001, and a memory store, opcode 6'b000010, each raise `end_o` in cycle 4.
- R4: A multiply, opcode 6'b000101, raises `end_o` in cycle 6.
- R5: Add (6'b000011), subtract (6'b000100) and every opcode not named in R2 to R4 raise `end_o` in cycle 3. Opcodes not named in R3 to R5 produce no writeback.
- R6: `end_o` is high for exactly one cycle per accepted instruction.
- R7: `acc_we_o` is high only in the `end_o` cycle, and only for load, add, subtract and multiply. `acc_sel_o` then selects the source: 2'd0 for memory read data (load), 2'd1 for the add/subtract result, and 2'd2 for the multiplier result. `flag_we_o` is high only in the `end_o` cycle of add and subtract.
- R8: `busy_o` is high from cycle 2 through cycle N inclusive and low otherwise. A start pulse seen while `busy_o` is high is ignored.
- R9: While `rst` is high at a clock edge, the counter, `busy_o`, `end_o` and all writeback enables are cleared after that edge, including in the middle of an instruction.
- R10: The opcode is captured on the accepting edge. Later changes of `instr_i` do not alter the running instruction's budget or its enables.
- R11: When `start_i` is held high continuously, a new instruction is accepted in the cycle after each `end_o` cycle, so back-to-back N-cycle instructions end every N cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 16 | Current instruction word, opcode in bits [15:10] |
| start_i | input | 1 | Start request, accepted only while idle |
| end_o | output | 1 | One-cycle end-of-instruction strobe |
| busy_o | output | 1 | Instruction in progress, through its end cycle |
| acc_we_o | output | 1 | Accumulator write enable |
| flag_we_o | output | 1 | Overflow flag write enable |
| acc_sel_o | output | 2 | Accumulator source: 0 memory, 1 add/sub, 2 multiply |

## Verification
The properties assume that `start_i` and `instr_i` change only between active clock edges and are at known levels whenever reset is low. They also assume that every configured budget is at least three cycles, which is what makes a strobe in the cycle right after acceptance impossible. The stimulus meets these conditions by driving every input on the falling clock edge and leaving the budgets at their defaults. It also deliberately sends start pulses during busy periods and during end cycles, and it changes `instr_i` right after acceptance, so that the ignore and capture rules are exercised rather than merely assumed.

// File: rtl/isq_pkg.sv
`timescale 1ns/1ps
package isq_pkg;

    localparam int unsigned INSTR_W = 16;
    localparam int unsigned OPC_HI  = 15;
    localparam int unsigned OPC_LO  = 10;
    localparam int unsigned OPC_W   = OPC_HI - OPC_LO + 1;

    // Accept cycle plus the registered strobe delay are not counted down
    localparam int unsigned PIPE_BIAS = 3;

    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b000001;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'b000010;
    localparam logic [OPC_W-1:0] OPC_ADD   = 6'b000011;
    localparam logic [OPC_W-1:0] OPC_SUB   = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_MUL   = 6'b000101;
    localparam logic [OPC_W-1:0] OPC_JUMP  = 6'b001000;

    typedef enum logic [2:0] {
        K_OTHER = 3'd0,
        K_JUMP  = 3'd1,
        K_LOAD  = 3'd2,
        K_STORE = 3'd3,
        K_ADD   = 3'd4,
        K_SUB   = 3'd5,
        K_MUL   = 3'd6
    } op_kind_e;

    typedef enum logic [1:0] {
        SRC_MEM    = 2'd0,
        SRC_ADDSUB = 2'd1,
        SRC_MULT   = 2'd2,
        SRC_NONE   = 2'd3
    } acc_src_e;

    typedef struct packed {
        logic     acc_we;
        logic     flag_we;
        acc_src_e src;
    } wb_ctrl_t;

    function automatic op_kind_e classify(input logic [OPC_W-1:0] opc);
        op_kind_e k;
        unique case (opc)
            OPC_LOAD:  k = K_LOAD;
            OPC_STORE: k = K_STORE;
            OPC_ADD:   k = K_ADD;
            OPC_SUB:   k = K_SUB;
            OPC_MUL:   k = K_MUL;
            OPC_JUMP:  k = K_JUMP;
            default:   k = K_OTHER;
        endcase
        return k;
    endfunction

    function automatic wb_ctrl_t wb_for(input op_kind_e k);
        wb_ctrl_t w;
        w = '{acc_we: 1'b0, flag_we: 1'b0, src: SRC_NONE};
        case (k)
            K_LOAD:       w = '{acc_we: 1'b1, flag_we: 1'b0, src: SRC_MEM};
            K_ADD, K_SUB: w = '{acc_we: 1'b1, flag_we: 1'b1, src: SRC_ADDSUB};
            K_MUL:        w = '{acc_we: 1'b1, flag_we: 1'b0, src: SRC_MULT};
            default:      w = '{acc_we: 1'b0, flag_we: 1'b0, src: SRC_NONE};
        endcase
        return w;
    endfunction

endpackage

// File: rtl/isq_decode.sv
`timescale 1ns/1ps
module isq_decode
    import isq_pkg::*;
#(
    parameter int unsigned CNT_W     = 3,
    parameter int unsigned LAT_JUMP  = 3,
    parameter int unsigned LAT_MEM   = 4,
    parameter int unsigned LAT_ALU   = 3,
    parameter int unsigned LAT_MUL   = 6,
    parameter int unsigned LAT_OTHER = 3
) (
    input  logic [OPC_W-1:0] opc_i,
    output op_kind_e         kind_o,
    output logic [CNT_W-1:0] preset_o
);

    // Counter preset = budget minus the cycles spent outside the count
    localparam logic [CNT_W-1:0] PRE_JUMP  = CNT_W'(LAT_JUMP  - PIPE_BIAS);
    localparam logic [CNT_W-1:0] PRE_MEM   = CNT_W'(LAT_MEM   - PIPE_BIAS);
    localparam logic [CNT_W-1:0] PRE_ALU   = CNT_W'(LAT_ALU   - PIPE_BIAS);
    localparam logic [CNT_W-1:0] PRE_MUL   = CNT_W'(LAT_MUL   - PIPE_BIAS);
    localparam logic [CNT_W-1:0] PRE_OTHER = CNT_W'(LAT_OTHER - PIPE_BIAS);

    op_kind_e kind;

    always_comb begin
        kind = classify(opc_i);
    end

    always_comb begin
        case (kind)
            K_JUMP:           preset_o = PRE_JUMP;
            K_LOAD, K_STORE:  preset_o = PRE_MEM;
            K_ADD, K_SUB:     preset_o = PRE_ALU;
            K_MUL:            preset_o = PRE_MUL;
            default:          preset_o = PRE_OTHER;
        endcase
    end

    assign kind_o = kind;

endmodule

// File: rtl/isq_counter.sv
`timescale 1ns/1ps
module isq_counter #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] preset_i,
    input  logic             run_i,
    output logic             term_o
);

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CNT_ZERO;
        end else if (load_i) begin
            cnt_q <= preset_i;
        end else if (run_i && (cnt_q != CNT_ZERO)) begin
            cnt_q <= cnt_q - CNT_ONE;
        end
    end

    // Decoded terminal condition, qualified by an active instruction
    assign term_o = run_i && (cnt_q == CNT_ZERO);

endmodule

// File: rtl/isq_wb_ctrl.sv
`timescale 1ns/1ps
module isq_wb_ctrl
    import isq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     accept_i,
    input  op_kind_e kind_i,
    input  logic     term_i,
    output logic     end_o,
    output logic     acc_we_o,
    output logic     flag_we_o,
    output acc_src_e src_o
);

    op_kind_e kind_q;
    logic     end_q;
    wb_ctrl_t wb;

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q <= K_OTHER;
        end else if (accept_i) begin
            kind_q <= kind_i;
        end
    end

    // Strobe registered one clock after the terminal count
    always_ff @(posedge clk) begin
        if (rst) begin
            end_q <= 1'b0;
        end else begin
            end_q <= term_i;
        end
    end

    always_comb begin
        wb = wb_for(kind_q);
    end

    assign end_o     = end_q;
    assign acc_we_o  = end_q & wb.acc_we;
    assign flag_we_o = end_q & wb.flag_we;
    assign src_o     = wb.src;

endmodule

// File: rtl/instr_cycle_seq.sv
`timescale 1ns/1ps
module instr_cycle_seq
    import isq_pkg::*;
#(
    parameter int unsigned CNT_W     = 3,
    parameter int unsigned LAT_JUMP  = 3,
    parameter int unsigned LAT_MEM   = 4,
    parameter int unsigned LAT_ALU   = 3,
    parameter int unsigned LAT_MUL   = 6,
    parameter int unsigned LAT_OTHER = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] instr_i,
    input  logic        start_i,
    output logic        end_o,
    output logic        busy_o,
    output logic        acc_we_o,
    output logic        flag_we_o,
    output logic [1:0]  acc_sel_o
);

    logic             accept;
    logic             run_q;
    logic             term;
    logic             end_s;
    op_kind_e         kind_d;
    acc_src_e         src;
    logic [CNT_W-1:0] preset;
    logic             unused_operand;

    assign unused_operand = ^instr_i[OPC_LO-1:0];

    // New work only when fully idle (end cycle counts as busy)
    assign accept = start_i & ~busy_o;

    isq_decode #(
        .CNT_W    (CNT_W),
        .LAT_JUMP (LAT_JUMP),
        .LAT_MEM  (LAT_MEM),
        .LAT_ALU  (LAT_ALU),
        .LAT_MUL  (LAT_MUL),
        .LAT_OTHER(LAT_OTHER)
    ) u_decode (
        .opc_i   (instr_i[OPC_HI:OPC_LO]),
        .kind_o  (kind_d),
        .preset_o(preset)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
        end else if (accept) begin
            run_q <= 1'b1;
        end else if (term) begin
            run_q <= 1'b0;
        end
    end

    isq_counter #(
        .CNT_W(CNT_W)
    ) u_counter (
        .clk     (clk),
        .rst     (rst),
        .load_i  (accept),
        .preset_i(preset),
        .run_i   (run_q),
        .term_o  (term)
    );

    isq_wb_ctrl u_wb (
        .clk      (clk),
        .rst      (rst),
        .accept_i (accept),
        .kind_i   (kind_d),
        .term_i   (term),
        .end_o    (end_s),
        .acc_we_o (acc_we_o),
        .flag_we_o(flag_we_o),
        .src_o    (src)
    );

    assign end_o     = end_s;
    assign busy_o    = run_q | end_s;
    assign acc_sel_o = src;

endmodule

// File: rtl/isq_chk.sv
`timescale 1ns/1ps
module isq_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] instr_i,
    input logic        start_i,
    input logic        end_o,
    input logic        busy_o,
    input logic        acc_we_o,
    input logic        flag_we_o,
    input logic [1:0]  acc_sel_o
);

    logic unused_instr;
    assign unused_instr = ^instr_i;

    // R6
    end_single_chk: assert property (@(posedge clk) disable iff (rst)
        end_o |=> !end_o);

    // R7
    acc_we_gated_chk: assert property (@(posedge clk) disable iff (rst)
        acc_we_o |-> end_o);

    // R7
    flag_we_src_chk: assert property (@(posedge clk) disable iff (rst)
        flag_we_o |-> (acc_we_o && acc_sel_o == 2'd1));

    // R8
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    // R8
    idle_after_end_chk: assert property (@(posedge clk) disable iff (rst)
        end_o |=> !busy_o);

    // R8
    end_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        end_o |-> busy_o);

    // R2
    no_early_end_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> !end_o);

endmodule

bind instr_cycle_seq isq_chk u_isq_chk (
    .clk      (clk),
    .rst      (rst),
    .instr_i  (instr_i),
    .start_i  (start_i),
    .end_o    (end_o),
    .busy_o   (busy_o),
    .acc_we_o (acc_we_o),
    .flag_we_o(flag_we_o),
    .acc_sel_o(acc_sel_o)
);

// File: tb/instr_cycle_seq_tb_top.sv
`timescale 1ns/1ps
module instr_cycle_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] instr = 16'h0000;
    logic        start = 1'b0;
    logic        end_o, busy_o, acc_we_o, flag_we_o;
    logic [1:0]  acc_sel_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    instr_cycle_seq dut_i (
        .clk      (clk),
        .rst      (rst),
        .instr_i  (instr),
        .start_i  (start),
        .end_o    (end_o),
        .busy_o   (busy_o),
        .acc_we_o (acc_we_o),
        .flag_we_o(flag_we_o),
        .acc_sel_o(acc_sel_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(req, "end_o", {31'd0, end_o}, 32'd0);
        chk(req, "busy_o", {31'd0, busy_o}, 32'd0);
        chk(req, "acc_we_o", {31'd0, acc_we_o}, 32'd0);
        chk(req, "flag_we_o", {31'd0, flag_we_o}, 32'd0);
    endtask

    // One instruction; sample m = negedge after accepting edge + (m-1)
    task automatic run_instr(input string req, input logic [5:0] opc,
                             input logic [9:0] low, input int n,
                             input bit we, input logic [1:0] sel,
                             input bit fl, input bit poke);
        @(negedge clk);
        instr = {opc, low};
        start = 1'b1;
        for (int m = 1; m <= n + 1; m++) begin
            @(negedge clk);
            if (m == 1) begin
                start = 1'b0;
                instr = {~opc, ~low}; // R10 capture at accept
            end
            chk(req, "end_o", {31'd0, end_o}, {31'd0, (m == n - 1)});
            chk(req, "busy_o", {31'd0, busy_o}, {31'd0, (m <= n - 1)});
            chk(req, "acc_we_o", {31'd0, acc_we_o}, {31'd0, (m == n - 1) && we});
            chk(req, "flag_we_o", {31'd0, flag_we_o}, {31'd0, (m == n - 1) && fl});
            if (m == n - 1 && we)
                chk(req, "acc_sel_o", {30'd0, acc_sel_o}, {30'd0, sel});
            if (poke && m == 1) begin
                start = 1'b1;               // R8 ignored while busy
                instr = {6'b000101, 10'd0};
            end
            if (poke && m == 2) start = 1'b0;
        end
    endtask

    task automatic t_reset_state;
        @(negedge clk);
        chk_idle("R9");
        rst = 1'b0;
        @(negedge clk);
        chk_idle("R9");
    endtask

    task automatic t_held_start;
        // R11: two jumps back to back, end in cycles 3 and 6
        @(negedge clk);
        instr = {6'b001000, 10'd0};
        start = 1'b1;
        for (int m = 1; m <= 7; m++) begin
            @(negedge clk);
            chk("R11", "end_o", {31'd0, end_o}, {31'd0, (m == 2 || m == 5)});
            chk("R11", "busy_o", {31'd0, busy_o},
                {31'd0, (m == 1 || m == 2 || m == 4 || m == 5)});
            if (m == 5) start = 1'b0;
        end
    endtask

    task automatic t_mid_reset;
        @(negedge clk);
        instr = {6'b000101, 10'd0};
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk_idle("R9");
        rst = 1'b0;
        for (int m = 0; m < 5; m++) begin
            @(negedge clk);
            chk_idle("R9");
        end
    endtask

    initial begin
        t_reset_state();
        run_instr("R2", 6'b001000, 10'h155, 3, 1'b0, 2'd0, 1'b0, 1'b0);
        run_instr("R3", 6'b000001, 10'h2AA, 4, 1'b1, 2'd0, 1'b0, 1'b0);
        run_instr("R3", 6'b000010, 10'h000, 4, 1'b0, 2'd0, 1'b0, 1'b0);
        run_instr("R4", 6'b000101, 10'h3FF, 6, 1'b1, 2'd2, 1'b0, 1'b0);
        run_instr("R5", 6'b000011, 10'h001, 3, 1'b1, 2'd1, 1'b1, 1'b0);
        run_instr("R5", 6'b000100, 10'h0F0, 3, 1'b1, 2'd1, 1'b1, 1'b0);
        run_instr("R5", 6'b111111, 10'h000, 3, 1'b0, 2'd0, 1'b0, 1'b0);
        // R1: low bits resemble a multiply code, opcode field is zero
        run_instr("R1", 6'b000000, 10'h005, 3, 1'b0, 2'd0, 1'b0, 1'b0);
        run_instr("R8", 6'b000001, 10'h000, 4, 1'b1, 2'd0, 1'b0, 1'b1);
        run_instr("R10", 6'b000101, 10'h000, 6, 1'b1, 2'd2, 1'b0, 1'b1);
        run_instr("R6", 6'b001000, 10'h000, 3, 1'b0, 2'd0, 1'b0, 1'b0);
        run_instr("R7", 6'b000011, 10'h000, 3, 1'b1, 2'd1, 1'b1, 1'b0);
        t_held_start();
        t_mid_reset();
        run_instr("R9", 6'b000001, 10'h000, 4, 1'b1, 2'd0, 1'b0, 1'b0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule